// File: doc/BRIEF.md
# Serial ADC Sample Reader

This block reads conversion results from a serial analog-to-digital converter over three wires: an active-low chip select, a serial clock that the block drives, and a serial data line that the converter drives. A start request pulls chip select low and the block runs one frame of 16 serial clock cycles. The converter sends four zero bits and then a 12-bit sample, most significant bit first. The block removes the four-bit prefix and checks that it is zero. It then presents the sample on a parallel bus together with a one-cycle valid strobe.

The serial clock rate comes from the system clock. A half-period input gives the number of system clocks in each serial clock phase, so the divide ratio is always even and never below 2. Between frames, chip select stays high for at least one full serial clock period. While the repeat input is held high, frames follow one another without further start requests.

Top module: `serial_adc_reader`

## Requirements
- R1: During and after reset, before any start, chip select is high, the serial clock is low, the sample bus is zero, and the valid and error outputs are low.
- R2: A start request in the idle state pulls chip select low on the next clock edge. Chip select then stays low for exactly 32·H system clocks, where H is the effective half period, and the serial clock rises exactly 16 times during that time.
- R3: The serial clock idles low. While a frame runs, each serial clock phase lasts H system clocks, with H equal to `half_period`, or 1 when `half_period` is 0. The period is therefore 2·H clocks.
- R4: The data line is sampled on each rising edge of the serial clock. The first bit received is stream bit 15. Sample bits 11..0 are stream bits 11..0, so the first data bit received after the prefix becomes sample bit 11.
- R5: `sample_valid` is high for exactly one clock cycle per frame, on the cycle in which chip select returns high. `sample` keeps its value until the next frame completes.
- R6: `frame_err` is high together with `sample_valid` exactly when any of stream bits 15..12 (the first four bits received) is 1. The sample is still delivered in that case, and `frame_err` is never high without `sample_valid`.
- R7: After a frame, chip select stays high for 2·H system clocks before the next frame can begin.
- R8: If `repeat_en` is high at the end of the inter-frame gap, the next frame starts without a start request. If it is low at that point, the block returns to idle.
- R9: A start request that arrives while a frame is being shifted has no effect. It does not extend the frame, and it does not queue another frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request one acquisition (taken in idle or at the end of a gap) |
| repeat_en | input | 1 | Keep acquiring frames back to back |
| half_period | input | DIV_W | System clocks per serial clock phase (0 is treated as 1) |
| adc_cs_n | output | 1 | Converter chip select, active low |
| adc_sclk | output | 1 | Serial clock to the converter |
| adc_sdata | input | 1 | Serial data from the converter |
| sample | output | DATA_W | Last received sample |
| sample_valid | output | 1 | One-cycle strobe when a new sample is ready |
| frame_err | output | 1 | Nonzero prefix detected, high with the strobe |

## Verification
The in-line assertions check on every cycle that:
- the serial clock stays low whenever chip select is high;
- the valid strobe lasts a single cycle and lines up with the rising edge of chip select;
- the error flag never appears without the strobe;
- the sample holds between strobes;
- chip select does not drop again on the cycle right after it rises.

Only the bench scenarios can show the rest:
- that each frame has exactly 16 serial clock rises;
- the exact phase and gap lengths for several divide settings, including the zero setting;
- that bits are assembled MSB first from a modelled converter;
- that repeat mode stops cleanly;
- that a start request in mid-frame is ignored.

// File: rtl/serial_adc_reader.sv
module serial_adc_reader #(
  parameter int DATA_W = 12,
  parameter int PAD_W  = 4,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              repeat_en,
  input  logic [DIV_W-1:0]  half_period,
  output logic              adc_cs_n,
  output logic              adc_sclk,
  input  logic              adc_sdata,
  output logic [DATA_W-1:0] sample,
  output logic              sample_valid,
  output logic              frame_err
);

  localparam int FRAME_W = DATA_W + PAD_W;
  localparam int IDX_W   = $clog2(FRAME_W);
  localparam int CNT_W   = DIV_W + 2;

  typedef enum logic [1:0] {S_IDLE, S_SHIFT, S_GAP} state_t;

  state_t             state;
  logic [CNT_W-1:0]   cnt;
  logic [IDX_W-1:0]   bit_idx;
  logic [FRAME_W-1:0] shreg;
  logic [CNT_W-1:0]   half_eff;
  logic [CNT_W-1:0]   gap_len;

  assign half_eff = (half_period == '0) ? CNT_W'(1) : CNT_W'(half_period);
  assign gap_len  = half_eff << 1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= S_IDLE;
      cnt          <= '0;
      bit_idx      <= '0;
      shreg        <= '0;
      adc_cs_n     <= 1'b1;
      adc_sclk     <= 1'b0;
      sample       <= '0;
      sample_valid <= 1'b0;
      frame_err    <= 1'b0;
    end else begin
      sample_valid <= 1'b0;
      frame_err    <= 1'b0;
      case (state)
        S_IDLE: begin
          if (start) begin
            state    <= S_SHIFT;
            adc_cs_n <= 1'b0;
            cnt      <= '0;
            bit_idx  <= '0;
          end
        end
        S_SHIFT: begin
          if (cnt >= half_eff - 1'b1) begin
            cnt      <= '0;
            adc_sclk <= ~adc_sclk;
            if (!adc_sclk) begin
              shreg <= {shreg[FRAME_W-2:0], adc_sdata};
            end else if (bit_idx == IDX_W'(FRAME_W - 1)) begin
              state        <= S_GAP;
              adc_cs_n     <= 1'b1;
              sample       <= shreg[DATA_W-1:0];
              sample_valid <= 1'b1;
              frame_err    <= |shreg[FRAME_W-1:DATA_W];
            end else begin
              bit_idx <= bit_idx + 1'b1;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_GAP: begin
          if (cnt >= gap_len - 1'b1) begin
            cnt <= '0;
            if (repeat_en || start) begin
              state    <= S_SHIFT;
              adc_cs_n <= 1'b0;
              bit_idx  <= '0;
            end else begin
              state <= S_IDLE;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R3
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adc_cs_n |-> !adc_sclk);

  // R5
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid |=> !sample_valid);

  // R5
  valid_at_cs_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid |-> $rose(adc_cs_n));

  // R5
  sample_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_valid |-> $stable(sample));

  // R6
  err_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |-> sample_valid);

  // R7
  gap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adc_cs_n) |=> adc_cs_n);

endmodule

// File: tb/serial_adc_reader_test.sv
`timescale 1ns/1ps
module serial_adc_reader_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic repeat_en = 1'b0;
  logic [7:0] half_period = 8'd1;
  logic adc_cs_n, adc_sclk, sample_valid, frame_err;
  logic adc_sdata = 1'b0;
  logic [11:0] sample;

  int tests = 0;
  int fails = 0;

  serial_adc_reader uut (
    .clk(clk), .rst_n(rst_n), .start(start), .repeat_en(repeat_en),
    .half_period(half_period), .adc_cs_n(adc_cs_n), .adc_sclk(adc_sclk),
    .adc_sdata(adc_sdata), .sample(sample), .sample_valid(sample_valid),
    .frame_err(frame_err)
  );

  always #4 clk = ~clk;

  logic [15:0] words [4];
  int fno = 0;
  int bidx = 0;
  int rises = 0;
  int vcnt = 0;
  logic [11:0] got_s [8];
  logic got_e [8];
  time t_fall = 0, t_rise = 0, last_rise = 0, per = 0, hi = 0, gap = 0;

  always @(negedge adc_cs_n) begin
    if (t_rise != 0) gap = $time - t_rise;
    t_fall = $time;
    last_rise = 0;
    bidx = 0;
    adc_sdata = words[fno][15];
  end
  always @(posedge adc_cs_n) begin
    t_rise = $time;
    if (rst_n) fno++;
  end
  always @(negedge adc_sclk) begin
    hi = $time - last_rise;
    if (!adc_cs_n) begin
      bidx++;
      if (bidx < 16) adc_sdata = words[fno % 4][15 - bidx];
    end
  end
  always @(posedge adc_sclk) begin
    if (last_rise != 0) per = $time - last_rise;
    last_rise = $time;
    rises++;
  end
  always @(posedge clk) begin
    if (sample_valid && vcnt < 8) begin
      got_s[vcnt] = sample;
      got_e[vcnt] = frame_err;
      vcnt++;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clocks(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic wait_valid(input int n);
    while (vcnt < n) @(negedge clk);
  endtask

  task automatic prep(input logic [7:0] h);
    half_period = h;
    fno = 0; vcnt = 0; rises = 0; t_rise = 0; gap = 0;
  endtask

  task automatic test_reset();
    clocks(3);
    chk("R1 cs_n", adc_cs_n, 1);
    chk("R1 sclk", adc_sclk, 0);
    chk("R1 sample", sample, 0);
    chk("R1 valid", sample_valid, 0);
    rst_n = 1'b1;
    clocks(5);
    chk("R1 idle cs_n", adc_cs_n, 1);
    chk("R1 idle err", frame_err, 0);
    chk("R1 idle sample", sample, 0);
  endtask

  task automatic test_single(input logic [7:0] h, input logic [15:0] w);
    int he;
    he = (h == 0) ? 1 : int'(h);
    prep(h);
    words[0] = w;
    pulse_start();
    wait_valid(1);
    clocks(10);
    chk("R4 sample", got_s[0], w[11:0]);
    chk("R6 err", got_e[0], |w[15:12]);
    chk("R2 rises", rises, 16);
    chk("R2 frame length", t_rise - t_fall, 32 * he * 8);
    chk("R3 period", per, 2 * he * 8);
    chk("R3 high phase", hi, he * 8);
    chk("R3 idle sclk", adc_sclk, 0);
    chk("R5 single strobe", vcnt, 1);
    chk("R5 hold", sample, w[11:0]);
  endtask

  task automatic test_repeat();
    prep(8'd2);
    words[0] = 16'h0321; words[1] = 16'h0FED; words[2] = 16'h4001; words[3] = 16'h0777;
    repeat_en = 1'b1;
    pulse_start();
    wait_valid(3);
    repeat_en = 1'b0;
    clocks(200);
    chk("R8 frame count", vcnt, 3);
    chk("R8 rises", rises, 48);
    chk("R4 repeat s0", got_s[0], 12'h321);
    chk("R4 repeat s1", got_s[1], 12'hFED);
    chk("R6 repeat s2 data", got_s[2], 12'h001);
    chk("R6 repeat e1", got_e[1], 0);
    chk("R6 repeat e2", got_e[2], 1);
    chk("R7 gap", gap, 2 * 2 * 8);
    chk("R8 idle", adc_cs_n, 1);
  endtask

  task automatic test_ignore();
    prep(8'd3);
    words[0] = 16'h0B0B;
    pulse_start();
    clocks(40);
    pulse_start();
    wait_valid(1);
    clocks(300);
    chk("R9 strobes", vcnt, 1);
    chk("R9 rises", rises, 16);
    chk("R9 frame length", t_rise - t_fall, 32 * 3 * 8);
    chk("R9 cs_n idle", adc_cs_n, 1);
    chk("R9 sample", sample, 12'hB0B);
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) words[i] = '0;
    test_reset();
    test_single(8'd1, 16'h0ABC);
    test_single(8'd4, 16'h0800);
    test_single(8'd0, 16'h0FFF);
    test_single(8'd2, 16'h0000);
    test_single(8'd3, 16'h8123);
    test_single(8'd1, 16'h1555);
    test_repeat();
    test_ignore();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule